// File: doc/BRIEF.md
# Multichannel Serial Training Pattern Selector

This block feeds eight per-channel bit serializers at the output stage of a 12-bit converter. For each channel it loads one 12-bit word every word period. The word is either the channel's live filtered sample or a link training word. The serializer shifts the word out most significant bit first, one bit per clock, and a shared frame strobe marks the first bit of every word. A receiver can use the training words to align its bit and word boundaries before live data is switched back on.

The source is chosen by a two-bit select field in a small register file. The field picks live data, a step word (six zeros followed by six ones), an alternating one/zero word, or a word that software programs. The user word is split across two byte-wide registers. All registers are written through a plain address/data write port and read back through a combinational read port. The select field and the user word are sampled only when a new word is loaded. A serialized word therefore never mixes two sources or two versions of the user word.

Top module: `lane_train_ser`

## Requirements
- R1: Each of the eight channels presents its loaded 12-bit word on its own `ser_out` bit, most significant bit first, one bit per clock cycle.
- R2: `frame_out` is high exactly in the first bit cycle of each word and low in the other eleven, so it repeats every 12 cycles.
- R3: With select value 0 (bits [1:0] of address 0x16), each channel serializes the value its `sample_in` slice (channel c at bits [12c+11:12c]) held at the clock edge where the word was loaded.
- R4: With select value 1, every channel serializes 0x03F (binary 000000111111).
- R5: With select value 2, every channel serializes 0xAAA (binary 101010101010).
- R6: With select value 3, every channel serializes the user word. Bits [7:0] of that word are written at address 0x10, and bits [3:0] written at address 0x11 become bits [11:8]. Bits [7:4] written at 0x11 are dropped.
- R7: Reading address 0x16 returns the select value in bits [1:0] and zeros above. Address 0x10 returns the low user byte. Address 0x11 returns user bits [11:8] in bits [3:0] and zeros in bits [7:4].
- R8: A write to the select field or the user word changes the output only from the next word load. A word already being shifted finishes unchanged. A write committed on the same edge as a load applies from the word after it.
- R9: While `rst_n` is low, `frame_out` and `ser_out` are zero, the select value is 0 and the user word is zero. The first word is loaded at the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| sample_in | input | 96 | Live samples, channel c at bits [12c+11:12c] |
| ser_out | output | 8 | Serial data, one bit per channel |
| frame_out | output | 1 | High during the first bit of each word |

## Verification
The two functions that can coincide are a register write and a word load. A write to the select field or to the user word can commit on the same rising edge where the serializers capture their next word. The bench provokes this by counting eleven cycles from an observed frame strobe and then issuing the write in the last bit cycle of the word. It then requires that the word starting at that edge still carries the old source and that only the following word carries the new one. A second case injects a user-word write halfway through a word, and that word must complete unchanged.

// File: rtl/lts_pkg.sv
package lts_pkg;

   typedef enum logic [1:0] {
      SRC_LIVE   = 2'b00,
      SRC_STEP   = 2'b01,
      SRC_TOGGLE = 2'b10,
      SRC_USER   = 2'b11
   } src_sel_e;

endpackage

// File: rtl/lts_regfile.sv
module lts_regfile
   import lts_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned WORD_W       = 12,
   parameter int unsigned SEL_ADDR     = 'h16,
   parameter int unsigned USER_LO_ADDR = 'h10,
   parameter int unsigned USER_HI_ADDR = 'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output src_sel_e          src_sel,
   output logic [WORD_W-1:0] user_word
);

   localparam int unsigned HI_W = WORD_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_ADDR);
   localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(USER_LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(USER_HI_ADDR);

   src_sel_e          sel_q;
   logic [DATA_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_LIVE;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_SEL) sel_q <= src_sel_e'(wr_data[1:0]);
         if (wr_addr == A_LO)  lo_q  <= wr_data;
         if (wr_addr == A_HI)  hi_q  <= wr_data[HI_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_SEL)     rd_data[1:0]      = sel_q;
      else if (rd_addr == A_LO) rd_data           = lo_q;
      else if (rd_addr == A_HI) rd_data[HI_W-1:0] = hi_q;
   end

   assign src_sel   = sel_q;
   assign user_word = {hi_q, lo_q};

endmodule

// File: rtl/lts_bit_timer.sv
module lts_bit_timer #(
   parameter int unsigned WORD_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic load_en,
   output logic frame_out
);

   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] bit_idx;

   // Parked on the last bit in reset so the first edge loads a word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_idx <= LAST;
      else if (load_en) bit_idx <= '0;
      else              bit_idx <= bit_idx + 1'b1;
   end

   assign load_en   = (bit_idx == LAST);
   assign frame_out = rst_n && (bit_idx == '0);

endmodule

// File: rtl/lts_word_mux.sv
module lts_word_mux
   import lts_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned WORD_W = 12
) (
   input  src_sel_e                 src_sel,
   input  logic [WORD_W-1:0]        user_word,
   input  logic [NUM_CH*WORD_W-1:0] live_in,
   output logic [NUM_CH*WORD_W-1:0] word_out
);

   function automatic logic [WORD_W-1:0] step_word();
      logic [WORD_W-1:0] w;
      for (int i = 0; i < WORD_W; i++) w[i] = (i < WORD_W / 2);
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] toggle_word();
      logic [WORD_W-1:0] w;
      for (int i = 0; i < WORD_W; i++) w[i] = ((WORD_W - 1 - i) % 2 == 0);
      return w;
   endfunction

   localparam logic [WORD_W-1:0] STEP_W   = step_word();
   localparam logic [WORD_W-1:0] TOGGLE_W = toggle_word();

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
         unique case (src_sel)
            SRC_STEP:   word_out[c*WORD_W +: WORD_W] = STEP_W;
            SRC_TOGGLE: word_out[c*WORD_W +: WORD_W] = TOGGLE_W;
            SRC_USER:   word_out[c*WORD_W +: WORD_W] = user_word;
            default:    word_out[c*WORD_W +: WORD_W] = live_in[c*WORD_W +: WORD_W];
         endcase
      end
   end

endmodule

// File: rtl/lts_shifter.sv
module lts_shifter #(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [WORD_W-1:0] word_in,
   output logic              ser_out
);

   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_en) sh_q <= word_in;
      else              sh_q <= {sh_q[WORD_W-2:0], 1'b0};
   end

   assign ser_out = sh_q[WORD_W-1];

endmodule

// File: rtl/lane_train_ser.sv
module lane_train_ser
   import lts_pkg::*;
#(
   parameter int unsigned NUM_CH       = 8,
   parameter int unsigned WORD_W       = 12,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SEL_ADDR     = 'h16,
   parameter int unsigned USER_LO_ADDR = 'h10,
   parameter int unsigned USER_HI_ADDR = 'h11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_CH*WORD_W-1:0] sample_in,
   output logic [NUM_CH-1:0]        ser_out,
   output logic                     frame_out
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the two-bit select field");
   end
   if (WORD_W <= DATA_W || WORD_W > 2 * DATA_W) begin : g_bad_word
      $error("WORD_W must span more than one and at most two registers");
   end
   if (SEL_ADDR == USER_LO_ADDR || SEL_ADDR == USER_HI_ADDR ||
       USER_LO_ADDR == USER_HI_ADDR) begin : g_bad_addr
      $error("register addresses must be distinct");
   end
   if (SEL_ADDR >= 2**ADDR_W || USER_LO_ADDR >= 2**ADDR_W ||
       USER_HI_ADDR >= 2**ADDR_W) begin : g_bad_range
      $error("register address exceeds ADDR_W");
   end

   src_sel_e                 src_sel;
   logic [WORD_W-1:0]        user_word;
   logic [NUM_CH*WORD_W-1:0] word_sel;
   logic                     load_en;

   lts_regfile #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .WORD_W      (WORD_W),
      .SEL_ADDR    (SEL_ADDR),
      .USER_LO_ADDR(USER_LO_ADDR),
      .USER_HI_ADDR(USER_HI_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .src_sel  (src_sel),
      .user_word(user_word)
   );

   lts_bit_timer #(.WORD_W(WORD_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .frame_out(frame_out)
   );

   lts_word_mux #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_mux (
      .src_sel  (src_sel),
      .user_word(user_word),
      .live_in  (sample_in),
      .word_out (word_sel)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      lts_shifter #(.WORD_W(WORD_W)) u_shift (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_en(load_en),
         .word_in(word_sel[c*WORD_W +: WORD_W]),
         .ser_out(ser_out[c])
      );
   end

endmodule

// File: rtl/lts_chk.sv
module lts_chk #(
   parameter int unsigned NUM_CH       = 8,
   parameter int unsigned WORD_W       = 12,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SEL_ADDR     = 'h16,
   parameter int unsigned USER_HI_ADDR = 'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic              frame_out,
   input logic [NUM_CH-1:0] ser_out,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);

   localparam int unsigned HI_W = WORD_W - DATA_W;

   int   gap_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else begin
         gap_q  <= frame_out ? 0 : gap_q + 1;
         seen_q <= seen_q | frame_out;
      end
   end

   // R2
   frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_out |=> !frame_out);

   // R2
   frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_out && seen_q) |-> (gap_q == WORD_W - 1));

   // R8
   load_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> frame_out);

   // R7
   sel_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(SEL_ADDR)) |-> (rd_data[DATA_W-1:2] == '0));

   // R7
   hi_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(USER_HI_ADDR)) |-> (rd_data[DATA_W-1:HI_W] == '0));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!frame_out && ser_out == '0));

endmodule

bind lane_train_ser lts_chk #(
   .NUM_CH      (NUM_CH),
   .WORD_W      (WORD_W),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .SEL_ADDR    (SEL_ADDR),
   .USER_HI_ADDR(USER_HI_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_en  (load_en),
   .frame_out(frame_out),
   .ser_out  (ser_out),
   .rd_addr  (rd_addr),
   .rd_data  (rd_data)
);

// File: tb/tb_lane_train_ser.sv
module tb_lane_train_ser;

   localparam int NCH = 8;
   localparam int WW  = 12;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_en;
   logic [7:0]      wr_addr, wr_data, rd_addr, rd_data;
   logic [NCH*WW-1:0] sample_in;
   logic [NCH-1:0]  ser_out;
   logic            frame_out;

   int checks = 0;
   int fails  = 0;
   logic [WW-1:0] cap [NCH];
   logic [WW-1:0] fr_vec;
   logic [WW-1:0] samp [NCH];

   always #5 clk = ~clk;

   lane_train_ser dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sample_in(sample_in), .ser_out(ser_out), .frame_out(frame_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_samples(input int seed);
      for (int c = 0; c < NCH; c++) begin
         samp[c] = WW'((seed * 1187 + c * 273 + (c ^ seed) * 31) % 4096);
         sample_in[c*WW +: WW] = samp[c];
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic wait_frame();
      while (frame_out !== 1'b1) @(negedge clk);
   endtask

   // Capture one word per channel; optionally inject a write at bit index inj_at.
   task automatic capture(input int inj_at, input logic [7:0] ia, input logic [7:0] id);
      wait_frame();
      for (int b = 0; b < WW; b++) begin
         for (int c = 0; c < NCH; c++) cap[c] = {cap[c][WW-2:0], ser_out[c]};
         fr_vec = {fr_vec[WW-2:0], frame_out};
         if (b == inj_at) begin
            wr_en = 1'b1; wr_addr = ia; wr_data = id;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   function automatic logic [WW-1:0] exp_word(input int src, input int c, input logic [WW-1:0] user);
      case (src)
         1: return WW'((1 << (WW / 2)) - 1);
         2: return WW'(4096 * 2 / 3);
         3: return user;
         default: return samp[c];
      endcase
   endfunction

   task automatic chk_word(input string req, input int src, input logic [WW-1:0] user);
      for (int c = 0; c < NCH; c++) chk(req, cap[c], exp_word(src, c, user));
   endtask

   task automatic configure(input int src, input logic [WW-1:0] user);
      wr(8'h10, user[7:0]);
      wr(8'h11, {4'hA, user[11:8]});
      wr(8'h16, 8'(src) | 8'hFC);
      wait_frame();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      set_samples(0);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 frame in reset", frame_out, 0);
      chk("R9 ser_out in reset", ser_out, 0);
      rd_chk("R9 select reset", 8'h16, 8'h00);
      rd_chk("R9 user lo reset", 8'h10, 8'h00);
      rd_chk("R9 user hi reset", 8'h11, 8'h00);

      set_samples(1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 first load at first edge", frame_out, 1);
      capture(-1, 0, 0);
      chk_word("R3 R1 live after reset", 0, '0);
      chk("R2 frame pattern", fr_vec, 12'h800);
      chk("R2 frame repeats", frame_out, 1);

      // R3 live sweep
      for (int s = 2; s < 8; s++) begin
         set_samples(s);
         wait_frame(); @(negedge clk);
         capture(-1, 0, 0);
         chk_word("R3 live sample", 0, '0);
         chk("R2 frame pattern", fr_vec, 12'h800);
      end

      // R4, R5 fixed words
      configure(1, 12'h000);
      rd_chk("R7 select readback", 8'h16, 8'h01);
      capture(-1, 0, 0);
      chk_word("R4 step word", 1, '0);
      configure(2, 12'h000);
      rd_chk("R7 select readback", 8'h16, 8'h02);
      capture(-1, 0, 0);
      chk_word("R5 alternating word", 2, '0);

      // R6 user word sweep with readback
      for (int k = 0; k < 6; k++) begin
         logic [WW-1:0] u;
         u = WW'((k * 1741 + 5) % 4096);
         if (k == 0) u = 12'hFFF;
         if (k == 1) u = 12'h801;
         configure(3, u);
         rd_chk("R7 select readback", 8'h16, 8'h03);
         rd_chk("R7 user lo readback", 8'h10, u[7:0]);
         rd_chk("R7 user hi readback", 8'h11, {4'h0, u[11:8]});
         capture(-1, 0, 0);
         chk_word("R6 user word", 3, u);
      end

      // R8 write on the load edge: user 0x5C3 active, switch to step word
      configure(3, 12'h5C3);
      wait_frame();
      repeat (WW - 1) @(negedge clk);
      wr(8'h16, 8'h01);
      chk("R8 frame at coincident edge", frame_out, 1);
      capture(-1, 0, 0);
      chk_word("R8 coincident write keeps old source", 3, 12'h5C3);
      capture(-1, 0, 0);
      chk_word("R8 new source next word", 1, '0);

      // R8 mid-word user-word change
      configure(3, 12'h3A6);
      capture(5, 8'h10, 8'h19);
      chk_word("R8 mid-word write ignored", 3, 12'h3A6);
      capture(-1, 0, 0);
      chk_word("R8 mid-word write applied next", 3, 12'h319);

      // R8 mid-word switch back to live
      set_samples(9);
      capture(3, 8'h16, 8'h00);
      chk_word("R8 select change mid-word", 3, 12'h319);
      capture(-1, 0, 0);
      chk_word("R3 R8 live after switch", 0, '0);

      finish_run();
   end

endmodule